// File: doc/BRIEF.md
# Interrupt Enable and Pending Bank

This block keeps an enable bit and a pending bit for each of 128 interrupt lines and picks one line to present to the processor. The enable bits sit behind a small memory-mapped register bus as four 32-bit words. Each word can be reached through two windows. A write of ones through the set window turns lines on, and a write of ones through the clear window turns them off. A read through either window returns the current enable state. Enables are never written directly.

An asserted line input always marks that line pending, whether or not the line is enabled. Each cycle, the lines that are both pending and enabled are eligible. The lowest-numbered eligible line is registered onto the active outputs. An acknowledge pulse carrying a line index clears that line's pending bit. Bus accesses made without the privileged qualifier are refused with an error and change nothing.

Bus responses come from a three-state machine: RSP_IDLE (no response this cycle), RSP_OK (a privileged access completes) and RSP_ERR (an unprivileged access is refused). From any state, the next state is RSP_OK after a privileged request, RSP_ERR after an unprivileged request, and RSP_IDLE when no request is made. Every request therefore gets exactly one response, in the following cycle.

Top module: `irq_enpend_bank`

## Requirements
- R1: After reset, all enable bits and all pending bits are 0, and act_valid and rsp_valid are low.
- R2: A privileged write to set word w (byte offset 0x100 + 4*w, w = 0..3) enables line 32*w + b for every bit b that is 1 in bus_wdata. Zero bits leave their lines unchanged.
- R3: A privileged write to clear word w (byte offset 0x180 + 4*w) disables line 32*w + b for every bit b that is 1 in bus_wdata. Zero bits leave their lines unchanged. Nothing else disables a line.
- R4: A privileged read of either set word w or clear word w returns, in bit b, the enable state of line 32*w + b (1 means enabled).
- R5: A 1 on irq_in[i] at a clock edge makes line i pending, whether or not it is enabled. A pending line that is disabled never appears on act_valid/act_idx. Once it is enabled it does appear.
- R6: act_valid and act_idx give, one cycle after the enable/pending state changes, the lowest index i whose line is both pending and enabled. act_valid is 0 when there is no such line.
- R7: ack_valid with ack_idx = i clears the pending bit of line i. If irq_in[i] is 1 in the same cycle, the line stays pending.
- R8: A request with bus_priv = 0 is answered with rsp_err = 1 and rsp_rdata = 0, and it changes no enable bit.
- R9: Every request gets rsp_valid in the next cycle, and no response is given without a request. A privileged access to an address outside the two windows, or to a non-word-aligned address, reads 0, raises no error and changes nothing. Write responses carry rsp_rdata = 0.
- R10: Disabling a line that is pending removes it from selection but keeps it pending, so enabling it again brings it back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Register access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_priv | input | 1 | Access is privileged |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Access refused (unprivileged) |
| rsp_rdata | output | 32 | Read data |
| irq_in | input | 128 | Interrupt line inputs, one bit per line |
| ack_valid | input | 1 | Acknowledge pulse |
| ack_idx | input | 7 | Line whose pending bit the acknowledge clears |
| act_valid | output | 1 | An eligible line exists |
| act_idx | output | 7 | Lowest eligible line |

## Verification
The bench raises a line while it is disabled and checks that nothing activates until the line is enabled. A design that gated pending capture with the enable would lose that interrupt, and one that ignored the enable would activate it at once. It writes zeros through both windows, and makes unprivileged writes to the clear window, then reads back to catch a design that overwrote enables or let a refused access through. It exercises the lowest-index choice at lines 0, 34, 70 and 127, and runs an acknowledge in the same cycle as a new assertion of that line. A design that let the acknowledge win, or that picked the highest index, would show the wrong act_idx. Misaligned and unmapped addresses check that decode does not alias onto real words.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
    localparam int WORD_W = 32;
    localparam logic [11:0] SET_BASE = 12'h100;
    localparam logic [11:0] CLR_BASE = 12'h180;

    typedef enum logic [1:0] {
        RSP_IDLE,
        RSP_OK,
        RSP_ERR
    } rsp_state_e;
endpackage

// File: rtl/irq_line_word.sv
module irq_line_word #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_en,
    input  logic [W-1:0] clr_en,
    input  logic [W-1:0] line_in,
    input  logic [W-1:0] ack_clr,
    output logic [W-1:0] en_q,
    output logic [W-1:0] pend_q
);
    // Enables: ones in the set mask turn lines on, ones in the clear mask turn them off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= (en_q | set_en) & ~clr_en;
        end
    end

    // Pending: a new line assertion takes precedence over an acknowledge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~ack_clr) | line_in;
        end
    end
endmodule

// File: rtl/irq_lowest_sel.sv
module irq_lowest_sel #(
    parameter int N     = 128,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     elig,
    output logic             act_valid,
    output logic [IDX_W-1:0] act_idx
);
    logic             found;
    logic [IDX_W-1:0] pick;

    // Scan from the top down so the lowest eligible index is the one left in pick.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_valid <= 1'b0;
            act_idx   <= '0;
        end else begin
            act_valid <= found;
            act_idx   <= pick;
        end
    end
endmodule

// File: rtl/irq_bus_fsm.sv
module irq_bus_fsm
    import irq_bank_pkg::*;
#(
    parameter int NWORDS = 4,
    parameter int ADDR_W = 12,
    localparam int TOT_W  = NWORDS * WORD_W,
    localparam int WSEL_W = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              priv,
    input  logic [TOT_W-1:0]  en_flat,
    output logic [TOT_W-1:0]  set_mask,
    output logic [TOT_W-1:0]  clr_mask,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [WORD_W-1:0] rsp_rdata
);
    localparam logic [ADDR_W-1:0] SPAN   = ADDR_W'(NWORDS * 4);
    localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(SET_BASE);
    localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_BASE);

    rsp_state_e        state_q, state_d;
    logic [ADDR_W-1:0] set_off, clr_off;
    logic              aligned, hit_set, hit_clr, hit_any;
    logic [WSEL_W-1:0] word_idx;
    logic              accept, wr_set, wr_clr;
    logic [WORD_W-1:0] rd_word, rdata_q;

    // Address decode
    always_comb begin
        set_off  = addr - SET_A;
        clr_off  = addr - CLR_A;
        aligned  = (addr[1:0] == 2'b00);
        hit_set  = aligned && (addr >= SET_A) && (set_off < SPAN);
        hit_clr  = aligned && (addr >= CLR_A) && (clr_off < SPAN);
        hit_any  = hit_set || hit_clr;
        word_idx = hit_clr ? WSEL_W'(clr_off >> 2) : WSEL_W'(set_off >> 2);
        accept   = req && priv;
        wr_set   = accept && we && hit_set;
        wr_clr   = accept && we && hit_clr;
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_word_mask
        assign set_mask[w*WORD_W +: WORD_W] =
            (wr_set && (word_idx == WSEL_W'(w))) ? wdata : '0;
        assign clr_mask[w*WORD_W +: WORD_W] =
            (wr_clr && (word_idx == WSEL_W'(w))) ? wdata : '0;
    end

    always_comb begin
        rd_word = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (hit_any && (word_idx == WSEL_W'(w))) begin
                rd_word = en_flat[w*WORD_W +: WORD_W];
            end
        end
    end

    // Next-state logic
    always_comb begin
        if (!req) begin
            state_d = RSP_IDLE;
        end else if (priv) begin
            state_d = RSP_OK;
        end else begin
            state_d = RSP_ERR;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            rdata_q <= (accept && !we) ? rd_word : '0;
        end
    end

    // Outputs from state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            RSP_IDLE: begin
                rsp_valid = 1'b0;
            end
            RSP_OK: begin
                rsp_valid = 1'b1;
                rsp_rdata = rdata_q;
            end
            RSP_ERR: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: begin
                rsp_valid = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/irq_enpend_bank.sv
module irq_enpend_bank
    import irq_bank_pkg::*;
#(
    parameter int NUM_LINES = 128,
    parameter int ADDR_W    = 12,
    localparam int NWORDS   = NUM_LINES / WORD_W,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_req,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [WORD_W-1:0]    bus_wdata,
    input  logic                 bus_priv,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [WORD_W-1:0]    rsp_rdata,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 ack_valid,
    input  logic [IDX_W-1:0]     ack_idx,
    output logic                 act_valid,
    output logic [IDX_W-1:0]     act_idx
);
    logic [NUM_LINES-1:0] en_vec, pend_vec;
    logic [NUM_LINES-1:0] set_mask, clr_mask, ack_vec;

    irq_bus_fsm #(
        .NWORDS (NWORDS),
        .ADDR_W (ADDR_W)
    ) i_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .priv      (bus_priv),
        .en_flat   (en_vec),
        .set_mask  (set_mask),
        .clr_mask  (clr_mask),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_ack
        assign ack_vec[i] = ack_valid && (ack_idx == IDX_W'(i));
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        irq_line_word #(
            .W (WORD_W)
        ) i_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_en  (set_mask[w*WORD_W +: WORD_W]),
            .clr_en  (clr_mask[w*WORD_W +: WORD_W]),
            .line_in (irq_in[w*WORD_W +: WORD_W]),
            .ack_clr (ack_vec[w*WORD_W +: WORD_W]),
            .en_q    (en_vec[w*WORD_W +: WORD_W]),
            .pend_q  (pend_vec[w*WORD_W +: WORD_W])
        );
    end

    irq_lowest_sel #(
        .N     (NUM_LINES),
        .IDX_W (IDX_W)
    ) i_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .elig      (en_vec & pend_vec),
        .act_valid (act_valid),
        .act_idx   (act_idx)
    );
endmodule

// File: rtl/irq_enpend_bank_chk.sv
module irq_enpend_bank_chk #(
    parameter int N     = 128,
    parameter int IDX_W = $clog2(N)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_req,
    input logic             bus_we,
    input logic             bus_priv,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [31:0]      rsp_rdata,
    input logic             act_valid,
    input logic [IDX_W-1:0] act_idx,
    input logic [N-1:0]     en_vec,
    input logic [N-1:0]     pend_vec
);
    logic [N-1:0] elig_now;
    assign elig_now = en_vec & pend_vec;

    // R1: while reset is held, outputs come up idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!act_valid && !rsp_valid));

    // R9: one response per request, in the following cycle
    assert_resp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> rsp_valid);
    assert_no_spurious_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !rsp_valid);

    // R8: unprivileged requests are refused with zero data
    assert_unpriv_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_priv) |=> (rsp_err && rsp_rdata == 32'h0));
    assert_err_only_unpriv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_priv) |=> !rsp_err);

    // R2 / R3 / R8: enables move only on a privileged write
    assert_en_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_priv && bus_we) |=> $stable(en_vec));

    // R5 / R6: a presented line was eligible in the previous cycle
    assert_act_eligible_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid |-> ((($past(elig_now)) >> act_idx) & N'(1)) != '0);
    assert_act_when_any_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(elig_now) != '0) |-> act_valid);
endmodule

bind irq_enpend_bank irq_enpend_bank_chk #(
    .N     (NUM_LINES),
    .IDX_W (IDX_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_we    (bus_we),
    .bus_priv  (bus_priv),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .act_valid (act_valid),
    .act_idx   (act_idx),
    .en_vec    (en_vec),
    .pend_vec  (pend_vec)
);

// File: tb/test_irq_enpend_bank.sv
`timescale 1ns/1ps
module test_irq_enpend_bank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0, bus_we = 1'b0, bus_priv = 1'b0;
    logic [11:0]  bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         rsp_valid, rsp_err;
    logic [31:0]  rsp_rdata;
    logic [127:0] irq_in = '0;
    logic         ack_valid = 1'b0;
    logic [6:0]   ack_idx = '0;
    logic         act_valid;
    logic [6:0]   act_idx;

    int checks = 0;
    int errors = 0;

    logic [127:0] en_m = '0;
    logic [127:0] pend_m = '0;
    logic [32:0]  exp_q[$];
    string        tag_q[$];

    always #2 clk = ~clk;

    irq_enpend_bank i_irq_enpend_bank (
        .clk, .rst_n, .bus_req, .bus_we, .bus_addr, .bus_wdata, .bus_priv,
        .rsp_valid, .rsp_err, .rsp_rdata, .irq_in, .ack_valid, .ack_idx,
        .act_valid, .act_idx
    );

    task automatic check(input bit ok, input string tag, input string act_s, input string exp_s);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %s expected %s", tag, act_s, exp_s);
        end
    endtask

    // Bench decode: returns word index, or -1 if unmapped
    function automatic int word_of(input logic [11:0] a);
        if (a[1:0] != 2'b00) return -1;
        if (a >= 12'h100 && a < 12'h110) return int'((a - 12'h100) >> 2);
        if (a >= 12'h180 && a < 12'h190) return int'((a - 12'h180) >> 2);
        return -1;
    endfunction

    // Driver: issue one access and push the expected response
    task automatic bus(input bit we, input logic [11:0] a, input logic [31:0] d,
                       input bit priv, input string tag);
        int w;
        logic [31:0] exp_d;
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d; bus_priv = priv;
        w = word_of(a);
        exp_d = (priv && !we && w >= 0) ? en_m[w*32 +: 32] : 32'h0;
        exp_q.push_back({!priv, exp_d});
        tag_q.push_back(tag);
        if (priv && we && w >= 0) begin
            if (a >= 12'h180) en_m[w*32 +: 32] = en_m[w*32 +: 32] & ~d;
            else              en_m[w*32 +: 32] = en_m[w*32 +: 32] | d;
        end
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    // Monitor: pop and compare every response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            logic [32:0] e;
            string t;
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected response", "rsp_valid", "none");
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({rsp_err, rsp_rdata} === e, t,
                      $sformatf("err=%0b data=%08h", rsp_err, rsp_rdata),
                      $sformatf("err=%0b data=%08h", e[32], e[31:0]));
            end
        end
    end

    task automatic pulse(input logic [127:0] m);
        @(negedge clk);
        irq_in = m;
        pend_m = pend_m | m;
        @(negedge clk);
        irq_in = '0;
    endtask

    task automatic ack(input int idx, input bit reassert);
        @(negedge clk);
        ack_valid = 1'b1;
        ack_idx = 7'(idx);
        pend_m[idx] = 1'b0;
        if (reassert) begin
            irq_in[idx] = 1'b1;
            pend_m[idx] = 1'b1;
        end
        @(negedge clk);
        ack_valid = 1'b0;
        irq_in = '0;
    endtask

    // Sample the selector one negedge after the stimulus task returns
    task automatic check_act(input string tag);
        logic [127:0] el;
        bit v;
        int ix;
        @(negedge clk);
        el = en_m & pend_m;
        v = 1'b0;
        ix = 0;
        for (int i = 127; i >= 0; i--) if (el[i]) begin v = 1'b1; ix = i; end
        check((act_valid === v) && (!v || act_idx === 7'(ix)), tag,
              $sformatf("v=%0b idx=%0d", act_valid, act_idx),
              $sformatf("v=%0b idx=%0d", v, ix));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check(!act_valid && !rsp_valid, "R1 reset outputs",
              $sformatf("act=%0b rsp=%0b", act_valid, rsp_valid), "act=0 rsp=0");
        rst_n = 1'b1;
        for (int w = 0; w < 4; w++) bus(1'b0, 12'(12'h100 + 4*w), '0, 1'b1, "R1 R4 enables zero after reset");

        // R2 / R4: set then read back through both windows
        bus(1'b1, 12'h104, 32'h0000_0005, 1'b1, "R2 set write");
        bus(1'b0, 12'h104, '0, 1'b1, "R2 R4 read set word");
        bus(1'b0, 12'h184, '0, 1'b1, "R4 read clear word");
        bus(1'b1, 12'h104, 32'h0, 1'b1, "R2 zero write");
        bus(1'b0, 12'h104, '0, 1'b1, "R2 zeros leave enables");

        // R5: disabled line captures pending but is not active
        pulse(128'(1) << 70);
        check_act("R5 disabled pending stays inactive");
        bus(1'b1, 12'h108, 32'h0000_0040, 1'b1, "R5 enable line 70");
        check_act("R5 enabled pending becomes active");

        // R6: lowest index wins
        pulse((128'(1) << 34) | (128'(1) << 100));
        check_act("R6 lowest index 34");

        // R7: acknowledge clears pending
        ack(34, 1'b0);
        check_act("R7 ack drops line 34");

        // R8: unprivileged access refused
        bus(1'b1, 12'h188, 32'h0000_0040, 1'b0, "R8 unpriv write error");
        bus(1'b0, 12'h108, '0, 1'b0, "R8 unpriv read zero");
        bus(1'b0, 12'h108, '0, 1'b1, "R8 enables unchanged");
        check_act("R8 selection unchanged");

        // R10 / R3: disable keeps pending, re-enable restores
        bus(1'b1, 12'h188, 32'h0000_0040, 1'b1, "R3 clear line 70");
        check_act("R10 disabled line drops from selection");
        bus(1'b0, 12'h108, '0, 1'b1, "R3 read after clear");
        bus(1'b1, 12'h108, 32'h0000_0040, 1'b1, "R10 re-enable");
        check_act("R10 pending line returns");
        bus(1'b1, 12'h188, 32'h0, 1'b1, "R3 zero clear write");
        bus(1'b0, 12'h188, '0, 1'b1, "R3 zeros leave enables");

        // R7: acknowledge with simultaneous assertion keeps pending
        ack(70, 1'b1);
        check_act("R7 reassert wins over ack");
        ack(70, 1'b0);
        check_act("R7 ack clears line 70");

        // R9: unmapped and misaligned accesses
        bus(1'b0, 12'h140, '0, 1'b1, "R9 unmapped read");
        bus(1'b1, 12'h105, 32'hFFFF_FFFF, 1'b1, "R9 misaligned write");
        bus(1'b1, 12'h110, 32'hFFFF_FFFF, 1'b1, "R9 past-end write");
        bus(1'b0, 12'h104, '0, 1'b1, "R9 word 1 unchanged");
        bus(1'b0, 12'h10C, '0, 1'b1, "R9 word 3 unchanged");

        // R6 boundaries: lines 127 and 0
        bus(1'b1, 12'h10C, 32'hFFFF_FFFF, 1'b1, "R2 enable word 3");
        check_act("R6 line 100 active");
        pulse(128'(1) << 127);
        ack(100, 1'b0);
        check_act("R6 top line 127");
        bus(1'b1, 12'h100, 32'h0000_0001, 1'b1, "R2 enable line 0");
        pulse(128'(1));
        check_act("R6 line 0 wins");
        bus(1'b0, 12'h18C, '0, 1'b1, "R4 clear window word 3");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R9 all responses seen",
              $sformatf("%0d left", exp_q.size()), "0 left");
        finish_run();
    end
endmodule